// File: doc/BRIEF.md
# Status Byte Service Request Generator

This block builds the 8-bit status byte that an instrument presents to a bus controller. Six live condition inputs are placed at fixed bit positions. A writable enable mask selects which of them may raise a service request. The block derives two things from the masked byte. The first is a level, the master summary, which is high while any enabled condition is present. The second is an edge-set request flag, which drives the service request line.

The status byte can be read at any time through a read port. In that byte, bit 6 shows the master summary, and reading has no side effects. A serial poll strobe is answered with the same byte, except that bit 6 carries the request flag as it stood before the poll. The poll then clears the flag and releases the line. The master summary can only be removed by withdrawing the condition or its enable bit. The request flag is raised again only on a fresh rising edge of the master summary.

Top module: `sb_srq_top`

## Requirements
- R1: After reset the enable register reads 0x00, the service request line is low, and with all conditions low both the status byte and the poll byte read 0x00.
- R2: The status byte maps conditions to bits as follows: bit 7 ramp done, bit 5 event summary, bit 4 sensor overload, bit 3 alarm, bit 2 measurement reading valid, bit 1 control reading valid. Bit 0 always reads 0.
- R3: Each status bit follows its input with one register stage of delay and is not latched. Removing the input clears the bit one cycle later.
- R4: A write to the enable register is visible on its read port on the cycle after the write. Bit 6 of the written value is ignored and always reads back as 0.
- R5: Bit 6 of the status read port (the master summary) is high exactly when some status bit and its enable bit are both 1.
- R6: On a rising edge of the master summary, the service request line goes high one cycle later.
- R7: While the poll strobe is high, the poll byte equals the status byte with bit 6 replaced by the current request flag.
- R8: The request flag and line clear on the cycle after a poll strobe. A poll leaves the master summary bit on the read port unchanged.
- R9: Reading the status byte clears nothing. Once set, the request flag stays high without a poll, even if the master summary falls.
- R10: After a poll, the flag is not set again while the master summary stays high. It is set again only after the summary falls and rises, whether the rise comes from the condition or from the enable bit.
- R11: If a master summary rising edge and a poll strobe fall in the same cycle, the request flag is set (set wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ramp_done_i | input | 1 | Ramp completed condition |
| evt_sum_i | input | 1 | Standard event summary condition |
| overload_i | input | 1 | Sensor overload condition |
| alarm_i | input | 1 | Visible alarm condition |
| meas_valid_i | input | 1 | Measurement input reading valid |
| ctrl_valid_i | input | 1 | Control input reading valid |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register read value |
| poll_i | input | 1 | Serial poll strobe, one cycle per poll |
| poll_byte_o | output | 8 | Poll response byte, bit 6 holds the request flag |
| stb_o | output | 8 | Status byte read port, bit 6 holds the master summary |
| srq_o | output | 1 | Service request line, active high |

## Verification
A request flag that is stuck, lost or set again would show on the service request line and on bit 6 of the poll byte within one or two cycles of the triggering condition, enable write or poll. A corrupted summary register or enable register shows on the status read port on the next cycle, because every status bit and the master summary bit are visible there without side effects. The cases that separate level from edge behaviour are the important ones. These are: a poll while the summary stays high, a summary that falls while the flag is set, and a poll that lands in the same cycle as a rising edge.

// File: rtl/sb_pkg.sv
// Package: constants shared by the status byte service request blocks.
// Assumes an 8-bit status byte with the summary/request bit at position 6.
package sb_pkg;
    localparam int SB_W      = 8;
    localparam int SB_MSS    = 6;
    localparam int SB_UNUSED = 0;
    localparam logic [SB_W-1:0] SB_MSS_MASK = SB_W'(1) << SB_MSS;
endpackage

// File: rtl/sb_summary_stage.sv
// Summary stage: registers each condition bit once, unlatched.
// Assumes the caller places conditions at their byte positions. The MSS
// position and the unused position are tied to 0 here.
module sb_summary_stage #(
    parameter int W       = sb_pkg::SB_W,
    parameter int MSS_POS = sb_pkg::SB_MSS,
    parameter int NUL_POS = sb_pkg::SB_UNUSED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_i,
    output logic [W-1:0] sum_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == MSS_POS || b == NUL_POS) begin : g_tie
            assign sum_o[b] = 1'b0;
        end else begin : g_reg
            logic q;
            // One register stage per condition bit, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= cond_i[b];
            end
            assign sum_o[b] = q;
        end
    end

    AST_SUM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sum_o == ($past(cond_i) & ~(W'(1) << MSS_POS) & ~(W'(1) << NUL_POS))); // R3
endmodule

// File: rtl/sb_enable_reg.sv
// Enable register: a writable mask for the service request. The MSS
// bit position is not stored and reads as 0.
// Assumes single-cycle write strobes. Resets to all zeros.
module sb_enable_reg #(
    parameter int W       = sb_pkg::SB_W,
    parameter int MSS_POS = sb_pkg::SB_MSS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o
);
    localparam logic [W-1:0] KEEP = ~(W'(1) << MSS_POS);
    logic [W-1:0] en_q;

    // Store written data with the MSS position masked off.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (we_i) en_q <= wdata_i & KEEP;
    end
    assign en_o = en_q;

    AST_EN_WRITE:  assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> en_o == ($past(wdata_i) & KEEP)); // R4
    AST_EN_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(en_o)); // R4
endmodule

// File: rtl/sb_rqs_ctrl.sv
// Request controller: sets the request flag on a rising edge of the
// master summary and clears it on the cycle after a poll. Set wins.
// Assumes mss_i is a registered-source level and poll_i a one-cycle strobe.
module sb_rqs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mss_i,
    input  logic poll_i,
    output logic rqs_o
);
    logic mss_q;
    logic rqs_q;
    logic rise;

    assign rise = mss_i && !mss_q;

    // Remember the previous master summary level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mss_q <= 1'b0;
        else        mss_q <= mss_i;
    end

    // Request flag: a rising edge sets it, a poll clears it, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      rqs_q <= 1'b0;
        else if (rise)   rqs_q <= 1'b1;
        else if (poll_i) rqs_q <= 1'b0;
    end
    assign rqs_o = rqs_q;

    AST_RQS_ON_RISE:   assert property (@(posedge clk) disable iff (!rst_n)
        (mss_i && !mss_q) |=> rqs_o); // R6
    AST_RQS_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rqs_o) |-> $past(mss_i && !mss_q)); // R10
    AST_POLL_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !(mss_i && !mss_q)) |=> !rqs_o); // R8
    AST_RQS_HOLDS:     assert property (@(posedge clk) disable iff (!rst_n)
        (rqs_o && !poll_i) |=> rqs_o); // R9
endmodule

// File: rtl/sb_srq_top.sv
// Status byte service request generator top. It assembles the status
// byte, masks it with the enable register to form the master summary,
// and drives the request line, the poll response and the read port.
// Assumes all inputs are synchronous to clk.
module sb_srq_top
    import sb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ramp_done_i,
    input  logic            evt_sum_i,
    input  logic            overload_i,
    input  logic            alarm_i,
    input  logic            meas_valid_i,
    input  logic            ctrl_valid_i,
    input  logic            en_we_i,
    input  logic [SB_W-1:0] en_wdata_i,
    output logic [SB_W-1:0] en_rdata_o,
    input  logic            poll_i,
    output logic [SB_W-1:0] poll_byte_o,
    output logic [SB_W-1:0] stb_o,
    output logic            srq_o
);
    logic [SB_W-1:0] cond;
    logic [SB_W-1:0] sum;
    logic [SB_W-1:0] en;
    logic            mss;
    logic            rqs;

    assign cond = {ramp_done_i, 1'b0, evt_sum_i, overload_i,
                   alarm_i, meas_valid_i, ctrl_valid_i, 1'b0};

    sb_summary_stage u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond),
        .sum_o  (sum)
    );

    sb_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (en_we_i),
        .wdata_i (en_wdata_i),
        .en_o    (en)
    );

    assign mss = |(sum & en);

    sb_rqs_ctrl u_rqs (
        .clk    (clk),
        .rst_n  (rst_n),
        .mss_i  (mss),
        .poll_i (poll_i),
        .rqs_o  (rqs)
    );

    assign stb_o       = sum | (mss ? SB_MSS_MASK : '0);
    assign poll_byte_o = sum | (rqs ? SB_MSS_MASK : '0);
    assign srq_o       = rqs;
    assign en_rdata_o  = en;

    AST_POLL_KEEPS_MSS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !en_we_i && $stable(cond)) |=> stb_o[SB_MSS] == $past(stb_o[SB_MSS])); // R8
    AST_BYTES_AGREE:    assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o & ~SB_MSS_MASK) == (poll_byte_o & ~SB_MSS_MASK)); // R7
endmodule

// File: tb/sb_srq_top_tb.sv
// Directed bench for sb_srq_top: one task per scenario.
module sb_srq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cnd = 8'h00;
    logic       en_we = 1'b0;
    logic [7:0] en_wdata = 8'h00;
    logic       poll = 1'b0;
    logic [7:0] en_rdata, poll_byte, stb;
    logic       srq;
    int         n_chk = 0;
    int         n_err = 0;

    always #2 clk = ~clk;

    sb_srq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ramp_done_i(cnd[7]), .evt_sum_i(cnd[5]), .overload_i(cnd[4]),
        .alarm_i(cnd[3]), .meas_valid_i(cnd[2]), .ctrl_valid_i(cnd[1]),
        .en_we_i(en_we), .en_wdata_i(en_wdata), .en_rdata_o(en_rdata),
        .poll_i(poll), .poll_byte_o(poll_byte), .stb_o(stb), .srq_o(srq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_en(logic [7:0] v);
        en_we = 1'b1; en_wdata = v;
        cyc(1);
        en_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 enable", en_rdata, 8'h00);
        chk("R1 srq", {7'd0, srq}, 8'h00);
        chk("R1 stb", stb, 8'h00);
        chk("R1 poll byte", poll_byte, 8'h00);
    endtask

    task automatic t_mapping;
        for (int b = 1; b < 8; b++) begin
            if (b != 6) begin
                cnd = 8'h01 << b;
                chk("R3 not yet", stb, 8'h00);
                cyc(1);
                chk("R2 bit map", stb, 8'h01 << b);
                cnd = 8'h00;
                cyc(1);
                chk("R3 unlatched", stb, 8'h00);
            end
        end
    endtask

    task automatic t_enable;
        wr_en(8'hFF);
        chk("R4 readback", en_rdata, 8'hBF);
        wr_en(8'h40);
        chk("R4 bit6 ignored", en_rdata, 8'h00);
        cnd = 8'hBE;
        cyc(1);
        chk("R5 no enable no mss", stb, 8'hBE);
        cyc(1);
        chk("R4 bit6 no srq", {7'd0, srq}, 8'h00);
        cnd = 8'h00;
        cyc(1);
    endtask

    task automatic t_request;
        wr_en(8'h10);
        cnd = 8'h10;
        cyc(1);
        chk("R5 mss", stb, 8'h50);
        chk("R6 srq not yet", {7'd0, srq}, 8'h00);
        cyc(1);
        chk("R6 srq set", {7'd0, srq}, 8'h01);
        cyc(3);
        chk("R9 read no clear srq", {7'd0, srq}, 8'h01);
        chk("R9 read no clear stb", stb, 8'h50);
    endtask

    task automatic t_poll;
        poll = 1'b1;
        chk("R7 poll byte", poll_byte, 8'h50);
        cyc(1);
        poll = 1'b0;
        chk("R8 srq cleared", {7'd0, srq}, 8'h00);
        chk("R8 mss kept", stb, 8'h50);
        chk("R7 poll byte after", poll_byte, 8'h10);
    endtask

    task automatic t_rearm;
        cyc(3);
        chk("R10 no rearm", {7'd0, srq}, 8'h00);
        cnd = 8'h00;
        cyc(1);
        chk("R5 source cleared", stb, 8'h00);
        cnd = 8'h10;
        cyc(2);
        chk("R10 rearm by source", {7'd0, srq}, 8'h01);
        wr_en(8'h00);
        chk("R9 mss cleared by enable", stb, 8'h10);
        cyc(1);
        chk("R9 flag holds after fall", {7'd0, srq}, 8'h01);
        poll = 1'b1;
        cyc(1);
        poll = 1'b0;
        chk("R8 cleared again", {7'd0, srq}, 8'h00);
        wr_en(8'h10);
        chk("R5 mss by enable", stb, 8'h50);
        cyc(1);
        chk("R10 rearm by enable", {7'd0, srq}, 8'h01);
    endtask

    task automatic t_setwins;
        wr_en(8'h00);
        chk("R9 mss low", stb, 8'h10);
        en_we = 1'b1; en_wdata = 8'h10;
        cyc(1);
        en_we = 1'b0;
        poll = 1'b1;
        chk("R11 poll byte", poll_byte, 8'h50);
        cyc(1);
        poll = 1'b0;
        chk("R11 set wins", {7'd0, srq}, 8'h01);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_mapping();
        t_enable();
        t_request();
        t_poll();
        t_rearm();
        t_setwins();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule